// File: doc/BRIEF.md
# Triangular Spread-Spectrum Offset Generator

This block produces a signed frequency-offset word that a downstream numerically controlled oscillator or fractional divider adds to its nominal increment, so that the output clock and the data launched from it are spread over a band and their emitted energy is lowered. The offset follows a symmetric triangle. One full triangle lasts 1024 reference clocks, so the modulation rate is the reference rate divided by 1024. A single select line picks the amplitude: a wide swing of ±4 % of nominal or a narrow swing of ±2 %.

The select line may come from another clock domain, so it passes through a synchronizer. When a change of the select is detected, the triangle restarts at its zero crossing with the new amplitude. A settling window of 32,800 reference cycles then begins. For that whole window a busy flag and a force-low indication are raised, so that the data path downstream holds its outputs low until the spread oscillator has settled. The same window also runs once after reset.

The offset is in units of 1/65536 of nominal. With phase `p` counting 0..1023 and peak `P`, the offset is `f(p) = floor(2·P·pos / 512) − P`, where `pos = p` for `p < 512` and `pos = 1024 − p` otherwise.

Top module: `ssc_profile_gen`

## Requirements
- R1: The phase advances by one at every rising edge outside reset and restart, and wraps modulo 1024. At every edge `offset_o` (signed, 16 bits) equals `f(phase)` for the amplitude in force. The phase is 256 (offset 0) at the reset edges and at the restart edge, so the output is on an up-ramp from zero.
- R2: While the select was 1 when last taken, the peak P is 2621.
- R3: While the select was 0 when last taken, the peak P is 1311.
- R4: The offset reaches exactly +P at phase 512 and exactly −P at phase 0, and turns back at each extreme.
- R5: `settling_o` is 1 for exactly 32,800 consecutive edges, counted from and including the edge that starts the window, and is 0 afterwards until the next window.
- R6: `force_low_o` equals `settling_o` in every cycle.
- R7: A change of `spread_wide_i` that happens between two edges takes effect at the third rising edge after the change. At that edge the amplitude switches, the phase restarts at 256 (offset 0) and a new settling window starts.
- R8: A change that is detected while a settling window is running restarts the window at its full length of 32,800 edges.
- R9: At every edge with `rst` high, `offset_o` becomes 0 and both flags become 1. If the select is held stable for at least three reset edges, the release of reset causes no change event, and the amplitude after reset is the one that the select gives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| spread_wide_i | input | 1 | Amplitude select, asynchronous: 1 = ±4 %, 0 = ±2 % |
| offset_o | output | 16 | Signed offset in 1/65536 of nominal |
| settling_o | output | 1 | Settling window running |
| force_low_o | output | 1 | Downstream data outputs must be held low |

## Verification
The bench follows the output for a full window and beyond with each amplitude. It checks the ±peak extremes and the turn-around at each of them, where a triangle with a wrong step or a wrong phase origin would overshoot or turn one cycle early. It changes the select and expects the restart on exactly the third edge. A synchronizer that is one stage too short or too long would move the zero-offset restart by one cycle and fail there. A second change lands in the middle of a running window, and a timer that did not reload would drop `settling_o` about 3,000 cycles too early.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

  typedef enum logic {
    SPREAD_NARROW = 1'b0,
    SPREAD_WIDE   = 1'b1
  } spread_e;

  typedef struct packed {
    logic    fire;
    spread_e sel;
  } sel_evt_t;

endpackage

// File: rtl/ssc_sel_sync.sv
module ssc_sel_sync #(
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_i,
  output ssc_pkg::sel_evt_t evt_o
);

  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] chain;
  logic              last_q;

  // Synchronizer flops carry no reset; they settle while reset is held.
  always_ff @(posedge clk) begin
    chain  <= {chain[STAGES-2:0], sel_i};
    last_q <= chain[TOP];
  end

  assign evt_o.fire = !rst && (chain[TOP] != last_q);
  assign evt_o.sel  = ssc_pkg::spread_e'(chain[TOP]);

endmodule

// File: rtl/ssc_settle_timer.sv
module ssc_settle_timer #(
  parameter int CYCLES = 32800
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy_o,
  output logic low_o
);

  localparam int CNT_W = $clog2(CYCLES);
  localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || start_i) begin
      cnt_q  <= LOAD_V;
      busy_o <= 1'b1;
      low_o  <= 1'b1;
    end else if (busy_o) begin
      if (cnt_q == '0) begin
        busy_o <= 1'b0;
        low_o  <= 1'b0;
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  // R5: the window opens only on a start request
  a_r5_rise_needs_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(start_i));

  // R5: the window closes only after the count has run out
  a_r5_fall_at_zero: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> ($past(cnt_q) == '0 && !$past(start_i)));

  // R6: the force-low flag tracks the busy flag
  a_r6_low_tracks_busy: assert property (@(posedge clk) disable iff (rst)
    low_o == busy_o);

  // R8: a start during a window reloads the full length
  a_r8_reload_full: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (busy_o && cnt_q == LOAD_V));

endmodule

// File: rtl/ssc_tri_profile.sv
module ssc_tri_profile #(
  parameter int HALF        = 512,
  parameter int OFF_W       = 16,
  parameter int PEAK_WIDE   = 2621,
  parameter int PEAK_NARROW = 1311
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    restart_i,
  input  ssc_pkg::spread_e        sel_i,
  output logic signed [OFF_W-1:0] offset_o
);

  localparam int PH_W   = $clog2(2 * HALF);
  localparam int SH     = $clog2(HALF);
  localparam int PROD_W = PH_W + OFF_W + 2;
  localparam int PK_MAX = (PEAK_WIDE > PEAK_NARROW) ? PEAK_WIDE : PEAK_NARROW;
  localparam logic [PH_W-1:0]    HALF_V  = PH_W'(HALF);
  localparam logic [PH_W-1:0]    START_V = PH_W'(HALF / 2);
  localparam logic [PH_W:0]      FULL_V  = (PH_W + 1)'(2 * HALF);
  localparam logic [OFF_W-1:0]   PK_W_V  = OFF_W'(PEAK_WIDE);
  localparam logic [OFF_W-1:0]   PK_N_V  = OFF_W'(PEAK_NARROW);
  localparam logic signed [OFF_W:0] STEP_MAX = (OFF_W + 1)'(2 * PK_MAX / HALF + 1);

  ssc_pkg::spread_e  sel_q, sel_n;
  logic [PH_W-1:0]   ph_q, ph_n;
  logic [PH_W:0]     pos_n;
  logic [OFF_W-1:0]  peak_n, peak_q;
  logic [PROD_W-1:0] prod_n;
  logic [OFF_W-1:0]  scaled_n;
  logic [OFF_W:0]    diff_n;

  always_comb begin
    sel_n  = (rst || restart_i) ? sel_i : sel_q;
    ph_n   = (rst || restart_i) ? START_V : ph_q + PH_W'(1);
    peak_n = (sel_n == ssc_pkg::SPREAD_WIDE) ? PK_W_V : PK_N_V;
    peak_q = (sel_q == ssc_pkg::SPREAD_WIDE) ? PK_W_V : PK_N_V;
    pos_n  = (ph_n < HALF_V) ? {1'b0, ph_n} : FULL_V - {1'b0, ph_n};
    prod_n = PROD_W'(pos_n) * PROD_W'({peak_n, 1'b0});
  end

  // The scaling variant depends on whether the half period is a power of two.
  if ((HALF & (HALF - 1)) == 0) begin : g_shift
    assign scaled_n = OFF_W'(prod_n >> SH);
  end else begin : g_div
    assign scaled_n = OFF_W'(prod_n / PROD_W'(HALF));
  end

  assign diff_n = {1'b0, scaled_n} - {1'b0, peak_n};

  always_ff @(posedge clk) begin
    sel_q    <= sel_n;
    ph_q     <= ph_n;
    offset_o <= diff_n[OFF_W-1:0];
  end

  logic signed [OFF_W:0] off_ext, pk_s;
  assign off_ext = {offset_o[OFF_W-1], offset_o};
  assign pk_s    = {1'b0, peak_q};

  // R2, R3: the offset never leaves the band of the selected amplitude
  a_r2_bounds: assert property (@(posedge clk) disable iff (rst)
    (off_ext <= pk_s) && (off_ext >= -pk_s));

  // R1: consecutive outputs differ by at most one step unless restarted
  a_r1_step_limit: assert property (@(posedge clk) disable iff (rst)
    !restart_i |=> ((off_ext - $past(off_ext)) <= STEP_MAX &&
                    (off_ext - $past(off_ext)) >= -STEP_MAX));

  // R4: the ramp turns downward after the positive extreme
  a_r4_turn_at_top: assert property (@(posedge clk) disable iff (rst)
    (off_ext == pk_s && !restart_i) |=> (off_ext < $past(off_ext)));

  // R4: the ramp turns upward after the negative extreme
  a_r4_turn_at_bottom: assert property (@(posedge clk) disable iff (rst)
    (off_ext == -pk_s && !restart_i) |=> (off_ext > $past(off_ext)));

endmodule

// File: rtl/ssc_profile_gen.sv
module ssc_profile_gen #(
  parameter int SYNC_STAGES   = 2,
  parameter int HALF_STEPS    = 512,
  parameter int OFF_W         = 16,
  parameter int PEAK_WIDE     = 2621,
  parameter int PEAK_NARROW   = 1311,
  parameter int SETTLE_CYCLES = 32800
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    spread_wide_i,
  output logic signed [OFF_W-1:0] offset_o,
  output logic                    settling_o,
  output logic                    force_low_o
);

  ssc_pkg::sel_evt_t evt;

  ssc_sel_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst   (rst),
    .sel_i (spread_wide_i),
    .evt_o (evt)
  );

  ssc_tri_profile #(
    .HALF        (HALF_STEPS),
    .OFF_W       (OFF_W),
    .PEAK_WIDE   (PEAK_WIDE),
    .PEAK_NARROW (PEAK_NARROW)
  ) u_profile (
    .clk       (clk),
    .rst       (rst),
    .restart_i (evt.fire),
    .sel_i     (evt.sel),
    .offset_o  (offset_o)
  );

  ssc_settle_timer #(
    .CYCLES (SETTLE_CYCLES)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .start_i (evt.fire),
    .busy_o  (settling_o),
    .low_o   (force_low_o)
  );

  // R7: a detected change restarts the profile at zero inside a window
  a_r7_restart_zero: assert property (@(posedge clk) disable iff (rst)
    evt.fire |=> (offset_o == '0 && settling_o && force_low_o));

endmodule

// File: tb/ssc_profile_gen_bench.sv
module ssc_profile_gen_bench;

  localparam int SETTLE = 32800;

  typedef struct {
    int off;
    bit busy;
    int tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel = 1'b0;
  logic signed [15:0] off_w;
  logic settling, force_low;

  always #4 clk = ~clk;

  ssc_profile_gen u_ssc_profile_gen (
    .clk           (clk),
    .rst           (rst),
    .spread_wide_i (sel),
    .offset_o      (off_w),
    .settling_o    (settling),
    .force_low_o   (force_low)
  );

  exp_t q[$];
  int checks = 0;
  int bad    = 0;
  bit done   = 1'b0;

  int m_ph   = 256;
  int m_busy = SETTLE;
  bit m_wide = 1'b0;
  bit m_next = 1'b0;
  int pend   = 0;

  function automatic int shape(int ph, bit wide);
    int pk  = wide ? 2621 : 1311;
    int pos = (ph < 512) ? ph : 1024 - ph;
    return ((2 * pk * pos) >>> 9) - pk;
  endfunction

  function automatic string tag_name(int t);
    case (t)
      2: return "R1 R2";
      3: return "R1 R3";
      4: return "R4";
      7: return "R7";
      8: return "R8";
      default: return "R9";
    endcase
  endfunction

  // Driver: advances one edge and pushes what the requirements predict.
  task automatic tick();
    exp_t e;
    @(posedge clk); #1;
    if (rst) begin
      m_ph = 256; m_busy = SETTLE; m_wide = sel; e.tag = 9;
    end else if (pend > 0 && pend == 1) begin
      pend = 0;
      e.tag = (m_busy > 0) ? 8 : 7;
      m_ph = 256; m_wide = m_next; m_busy = SETTLE;
    end else begin
      if (pend > 0) pend = pend - 1;
      m_ph = (m_ph + 1) % 1024;
      if (m_busy > 0) m_busy = m_busy - 1;
      if (m_ph == 0 || m_ph == 512) e.tag = 4;
      else e.tag = m_wide ? 2 : 3;
    end
    e.off  = shape(m_ph, m_wide);
    e.busy = (m_busy > 0);
    q.push_back(e);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic set_sel(bit v);
    sel = v; m_next = v; pend = 3;
  endtask

  // Monitor: pops one expectation per cycle, away from the active edge.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks = checks + 1;
      if (int'(off_w) != e.off) begin
        bad = bad + 1;
        $display("FAIL %s offset actual=%0d expected=%0d", tag_name(e.tag), int'(off_w), e.off);
      end
      checks = checks + 1;
      if (settling != e.busy) begin
        bad = bad + 1;
        $display("FAIL R5 settling actual=%0b expected=%0b (%s)", settling, e.busy, tag_name(e.tag));
      end
      checks = checks + 1;
      if (force_low != e.busy) begin
        bad = bad + 1;
        $display("FAIL R6 force_low actual=%0b expected=%0b", force_low, e.busy);
      end
    end
  end

  initial begin
    rst = 1'b1; sel = 1'b0;
    run(4);                 // R9: reset state, select settles
    rst = 1'b0;
    run(34000);             // R3, R4, R5: narrow triangle, window end
    set_sel(1'b1);
    run(34000);             // R7, R2: wide triangle after restart
    set_sel(1'b0);
    run(3000);
    set_sel(1'b1);          // R8: change inside a running window
    run(34000);
    @(negedge clk); @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad = bad + 1;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule